// File: doc/BRIEF.md
# Filter Coefficient Loader

This controller fills the coefficient register file of a FIR filter. In memory mode it runs on its own: as soon as reset is released it reads a complete set of 128 sixteen-bit coefficients out of an external byte-wide read-only memory and writes them, one at a time, into the filter's coefficient store. A rising edge on the change-request input runs the same full load again. Because the memory address carries a 4-bit device index, up to sixteen filters can hang on one shared memory, each reading its own 256-byte region, with no host involved.

In host mode the automatic and requested loads are switched off and a host writes individual coefficients straight through to the coefficient port. While a load is running a busy flag is high and the filter's output-valid enable is held low. Each memory byte is given a programmable number of extra clocks of access time before it is sampled, so slow memories can be attached with no glue logic.

Top module: `coeff_loader`

## Requirements
- R1: While reset is asserted (active low) in memory mode, `busy`, `cf_we` and `out_valid` are all low.
- R2: In memory mode a full load begins by itself at the first clock edge after reset is released, so `busy` is high from that edge on.
- R3: During a load `mem_addr` is `{dev_id, coefficient number, byte select}` (byte select in bit 0, 0 = low byte); each address is held for `access_wait`+1 cycles and the data is taken in the last of them, so a load keeps `busy` high for exactly 256*(`access_wait`+1) cycles.
- R4: Every coefficient is written once, in ascending index order 0 to 127, with `cf_data` = {byte at odd address, byte at even address}; the write strobe coincides with sampling the high byte.
- R5: `out_valid` is low while `busy` is high and from reset until the first load completes, and high in memory mode once a load has completed.
- R6: A rising edge on `chg_req` while idle in memory mode starts a new full load.
- R7: A rising edge on `chg_req` during a load is remembered; the next full load begins one clock after `busy` falls (busy is low for exactly one cycle).
- R8: In host mode no load starts, neither after reset nor on `chg_req`; `busy` stays low and `out_valid` is high.
- R9: In host mode while idle, `host_wr`, `host_idx` and `host_data` appear on `cf_we`, `cf_idx` and `cf_data` in the same cycle.
- R10: `host_wr` has no effect in memory mode, including during a load: no extra coefficient write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_id | input | DEV_W (4) | Device index selecting this filter's memory region |
| host_mode | input | 1 | 1 = host writes, 0 = self-loading from memory |
| chg_req | input | 1 | Change-coefficient request, rising edge acts |
| access_wait | input | WAIT_W (3) | Extra clocks of memory access time per byte |
| mem_addr | output | DEV_W+CIDX_W+1 (12) | Byte address to the external memory |
| mem_data | input | CW/2 (8) | Byte returned by the external memory |
| host_wr | input | 1 | Host coefficient write strobe |
| host_idx | input | CIDX_W (7) | Host coefficient index |
| host_data | input | CW (16) | Host coefficient value |
| busy | output | 1 | High throughout a memory load |
| out_valid | output | 1 | Filter output enable, low until coefficients are in place |
| cf_we | output | 1 | Coefficient write strobe toward the filter |
| cf_idx | output | CIDX_W (7) | Coefficient index being written |
| cf_data | output | CW (16) | Coefficient value being written |

## Verification
The bench builds the block with its default parameters: a 4-bit device index, 128 coefficients of 16 bits and a 3-bit access-wait field. This puts the full address range, the last coefficient, and every wait setting from 0 to 7 within reach, and the bench's memory model returns garbage until the chosen number of wait cycles has passed, so sampling one cycle early is caught. Random device indices and wait settings are mixed with directed cases for a request during a load, host writes during a load and host mode at reset.

// File: rtl/coeff_loader.sv
module coeff_loader #(
  parameter int DEV_W  = 4,
  parameter int CIDX_W = 7,
  parameter int CW     = 16,
  parameter int WAIT_W = 3,
  localparam int BW = CW / 2,
  localparam int AW = DEV_W + CIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev_id,
  input  logic              host_mode,
  input  logic              chg_req,
  input  logic [WAIT_W-1:0] access_wait,
  output logic [AW-1:0]     mem_addr,
  input  logic [BW-1:0]     mem_data,
  input  logic              host_wr,
  input  logic [CIDX_W-1:0] host_idx,
  input  logic [CW-1:0]     host_data,
  output logic              busy,
  output logic              out_valid,
  output logic              cf_we,
  output logic [CIDX_W-1:0] cf_idx,
  output logic [CW-1:0]     cf_data
);

  logic              busy_q, loaded_q, pend_q, chg_q, hi_q;
  logic [CIDX_W-1:0] coef_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [BW-1:0]     lo_q;

  wire chg_edge = chg_req & ~chg_q;
  wire start    = ~busy_q & pend_q & ~host_mode;
  wire sample   = busy_q & (cnt_q >= access_wait);
  wire last     = sample & hi_q & (&coef_q);
  wire host_go  = host_mode & ~busy_q & host_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      loaded_q <= 1'b0;
      pend_q   <= 1'b1;
      chg_q    <= 1'b0;
      hi_q     <= 1'b0;
      coef_q   <= '0;
      cnt_q    <= '0;
      lo_q     <= '0;
    end else begin
      chg_q  <= chg_req;
      pend_q <= host_mode ? 1'b0 : ((pend_q & ~start) | chg_edge);
      if (start) begin
        busy_q <= 1'b1;
        hi_q   <= 1'b0;
        coef_q <= '0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (sample) begin
          cnt_q <= '0;
          hi_q  <= ~hi_q;
          if (!hi_q) lo_q <= mem_data;
          else       coef_q <= coef_q + 1'b1;
          if (last) begin
            busy_q   <= 1'b0;
            loaded_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign mem_addr  = {dev_id, coef_q, hi_q};
  assign busy      = busy_q;
  assign out_valid = ~busy_q & (loaded_q | host_mode);
  assign cf_we     = (sample & hi_q) | host_go;
  assign cf_idx    = busy_q ? coef_q : host_idx;
  assign cf_data   = busy_q ? {mem_data, lo_q} : host_data;

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q < access_wait && $stable(dev_id)) |=> $stable(mem_addr));

  // R4
  hi_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cf_we) |-> mem_addr[0]);

  // R5
  valid_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid);

  // R5
  valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);

  // R8
  host_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && !busy) |=> !busy);

  // R10
  mem_mode_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && !busy) |-> !cf_we);

endmodule

// File: tb/coeff_loader_tb.sv
module coeff_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dev_id = '0;
  logic        host_mode = 1'b0;
  logic        chg_req = 1'b0;
  logic [2:0]  access_wait = '0;
  logic [11:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic        host_wr = 1'b0;
  logic [6:0]  host_idx = '0;
  logic [15:0] host_data = '0;
  logic        busy, out_valid, cf_we;
  logic [6:0]  cf_idx;
  logic [15:0] cf_data;

  coeff_loader u_dut (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .host_mode(host_mode),
    .chg_req(chg_req), .access_wait(access_wait), .mem_addr(mem_addr),
    .mem_data(mem_data), .host_wr(host_wr), .host_idx(host_idx),
    .host_data(host_data), .busy(busy), .out_valid(out_valid),
    .cf_we(cf_we), .cf_idx(cf_idx), .cf_data(cf_data)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int wr_cnt = 0, busy_cnt = 0, order_err = 0, next_idx = 0;
  logic [15:0] got [128];
  logic [11:0] last_addr = '0;
  int age = 0;

  function automatic logic [7:0] rom(input logic [11:0] a);
    logic [11:0] t;
    t = a * 12'd73;
    return t[7:0] ^ a[11:4] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] exp_coef(input logic [3:0] d, input int i);
    return {rom({d, 7'(i), 1'b1}), rom({d, 7'(i), 1'b0})};
  endfunction

  always @(negedge clk) begin
    if (mem_addr != last_addr) begin
      age = 0;
      last_addr = mem_addr;
    end else if (age < 100) begin
      age = age + 1;
    end
    mem_data = (age >= int'(access_wait)) ? rom(mem_addr) : (8'hEE ^ mem_addr[7:0]);
  end

  always @(negedge clk) begin
    #1;
    if (busy) busy_cnt = busy_cnt + 1;
    if (cf_we) begin
      wr_cnt = wr_cnt + 1;
      got[cf_idx] = cf_data;
      if (busy) begin
        if (int'(cf_idx) != next_idx) order_err = order_err + 1;
        next_idx = (next_idx + 1) % 128;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    wr_cnt = 0; busy_cnt = 0; order_err = 0; next_idx = 0;
    for (int i = 0; i < 128; i++) got[i] = 16'hxxxx;
  endtask

  task automatic wait_fall();
    @(negedge clk); #2;
    while (!busy) begin @(negedge clk); #2; end
    while (busy) begin @(negedge clk); #2; end
  endtask

  task automatic check_set(input string req, input logic [3:0] d);
    int bad = 0;
    for (int i = 0; i < 128; i++)
      if (got[i] !== exp_coef(d, i)) bad = bad + 1;
    chk(req, 32'(bad), 32'd0);
    chk(req, 32'(order_err), 32'd0);
  endtask

  task automatic pulse_chg();
    @(posedge clk); #1 chg_req = 1'b1;
    @(posedge clk); #1 chg_req = 1'b0;
  endtask

  task automatic load_run(input logic [3:0] d, input logic [2:0] w);
    @(posedge clk); #1;
    dev_id = d; access_wait = w;
    clear_counts();
    pulse_chg();
    wait_fall();
    chk("R6 writes", 32'(wr_cnt), 32'd128);
    chk("R3 busy cycles", 32'(busy_cnt), 32'(256 * (int'(w) + 1)));
    check_set("R4 coefficient set", d);
    chk("R5 valid after load", 32'(out_valid), 32'd1);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    dev_id = 4'd5; access_wait = 3'd2;
    clear_counts();
    #35;
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 we in reset", 32'(cf_we), 32'd0);
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R2 busy after reset", 32'(busy), 32'd1);
    chk("R5 valid during load", 32'(out_valid), 32'd0);
    while (busy) begin @(negedge clk); #2; end
    chk("R2 writes", 32'(wr_cnt), 32'd128);
    chk("R3 busy cycles", 32'(busy_cnt), 32'd768);
    check_set("R4 coefficient set", 4'd5);
    chk("R5 valid after load", 32'(out_valid), 32'd1);

    load_run(4'd9, 3'd0);
    load_run(4'd15, 3'd7);
    for (int k = 0; k < 3; k++)
      load_run(4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)));

    // R7 and R10: request and host write during a load
    @(posedge clk); #1;
    dev_id = 4'd2; access_wait = 3'd1;
    clear_counts();
    pulse_chg();
    repeat (40) @(posedge clk);
    #1 host_wr = 1'b1; host_idx = 7'd3; host_data = 16'hABCD;
    @(posedge clk); #1 host_wr = 1'b0;
    pulse_chg();
    while (!(busy === 1'b0)) begin @(negedge clk); #2; end
    chk("R7 gap cycle", 32'(busy), 32'd0);
    chk("R10 writes after first load", 32'(wr_cnt), 32'd128);
    chk("R10 coef 3 untouched", 32'(got[3]), 32'(exp_coef(4'd2, 3)));
    @(negedge clk); #2;
    chk("R7 reload started", 32'(busy), 32'd1);
    while (busy) begin @(negedge clk); #2; end
    chk("R7 writes both loads", 32'(wr_cnt), 32'd256);
    chk("R7 busy cycles", 32'(busy_cnt), 32'd1024);
    check_set("R7 coefficient set", 4'd2);

    // R10: host write idle in memory mode
    clear_counts();
    @(posedge clk); #1 host_wr = 1'b1; host_idx = 7'd9; host_data = 16'h1234;
    @(negedge clk); #2;
    chk("R10 idle memory mode", 32'(cf_we), 32'd0);
    @(posedge clk); #1 host_wr = 1'b0;

    // R8, R9: host mode
    host_mode = 1'b1;
    clear_counts();
    for (int k = 0; k < 20; k++) begin
      logic [6:0]  ri;
      logic [15:0] rd;
      logic        rw;
      ri = 7'($urandom_range(0, 127));
      rd = 16'($urandom);
      rw = 1'($urandom_range(0, 1));
      @(posedge clk); #1 host_wr = rw; host_idx = ri; host_data = rd;
      @(negedge clk); #2;
      chk("R9 strobe", 32'(cf_we), 32'(rw));
      if (rw) begin
        chk("R9 index", 32'(cf_idx), 32'(ri));
        chk("R9 data", 32'(cf_data), 32'(rd));
      end
    end
    @(posedge clk); #1 host_wr = 1'b0;
    pulse_chg();
    repeat (30) @(posedge clk);
    #1;
    chk("R8 no load on request", 32'(busy_cnt), 32'd0);
    chk("R8 valid in host mode", 32'(out_valid), 32'd1);

    // R8: reset in host mode
    rst_n = 1'b0;
    clear_counts();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (30) @(posedge clk);
    #1;
    chk("R8 no load after reset", 32'(busy_cnt), 32'd0);
    chk("R8 busy low", 32'(busy), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule